// File: doc/BRIEF.md
# Frame-Granular XON/XOFF Stream Gate

This block sits in a framed stream made of a valid strobe, a start-of-frame mark, an end-of-frame mark and a data word. The stream has no flow control of its own. The block adds on/off gating at frame granularity, driven by a single `xon` level that comes from downstream. Each frame either passes in full or is dropped in full; the gate never cuts a frame in the middle. The same `xon` level is passed back upstream, so a source that already honours `xon` can sit in front of the gate.

The pass or drop choice is made only on the beat that carries the start mark. That choice then holds for every beat up to and including the matching end mark. As a result, a frame that is already in flight when `xon` falls still completes. When `xon` rises part-way through a frame, output resumes only with the next frame. In normal mode the output is registered, one cycle behind the input. With the `BYPASS` parameter set, the block is a plain wire.

Top module: `stream_xon_gate`

## Requirements
- R1: `in_xon_o` equals `out_xon_i` in every cycle, in both modes.
- R2: While `rst_ni` is low, and in the first cycle after reset, `out_valid_o`, `out_sop_o` and `out_eop_o` are 0.
- R3: If a start beat (`in_valid_i`=1, `in_sop_i`=1) arrives with `out_xon_i`=1, its frame is forwarded. Each beat appears exactly one cycle later, with data, sop and eop unchanged.
- R4: If a start beat arrives with `out_xon_i`=0, every beat of that frame is dropped, its end beat included. This holds even if `out_xon_i` rises before the frame ends.
- R5: A frame that is being forwarded completes through its end beat, even if `out_xon_i` falls part-way through.
- R6: A valid beat without `in_sop_i` that arrives outside any frame (no start since the last end beat) is dropped.
- R7: A single-beat frame (`in_sop_i`=1 and `in_eop_i`=1 on the same beat) is forwarded or dropped according to `out_xon_i` in that cycle. It leaves no frame open behind it.
- R8: `out_sop_o` and `out_eop_o` are 0 in any cycle where `out_valid_o` is 0.
- R9: With `BYPASS`=1, `out_valid_o`, `out_sop_o`, `out_eop_o` and `out_data_o` equal the inputs in the same cycle, whatever the value of `xon`.
- R10: Cycles with `in_valid_i`=0 inside a frame neither end the frame nor change its pass or drop choice, and they produce no output beat.
- R11: A start beat that arrives while a frame is still open (no end beat seen yet) starts a new frame. That frame gets a fresh choice from `out_xon_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat valid |
| in_sop_i | input | 1 | Input start-of-frame mark |
| in_eop_i | input | 1 | Input end-of-frame mark |
| in_data_i | input | DATA_W | Input data word |
| in_xon_o | output | 1 | xon passed back to the upstream source |
| out_xon_i | input | 1 | xon from downstream |
| out_valid_o | output | 1 | Output beat valid |
| out_sop_o | output | 1 | Output start-of-frame mark |
| out_eop_o | output | 1 | Output end-of-frame mark |
| out_data_o | output | DATA_W | Output data word |

## Verification
The assertions assume that `in_sop_i` and `in_eop_i` carry meaning only when `in_valid_i` is high. They also assume that `out_xon_i` is a level synchronous to `clk_i`, free to change in any cycle. The stimulus never marks a start or end without a valid beat. Beyond that rule it is left unconstrained: frames with idle gaps, single-beat frames, stray beats with no start, and starts that arrive before the previous end. This means R6 and R11 are exercised as well as well-formed traffic. `xon` toggles both at frame edges and mid-frame, so it hits the cases covered by R4 and R5.

// File: rtl/xg_pkg.sv
package xg_pkg;
  typedef struct packed {
    logic valid;
    logic sop;
    logic eop;
  } xg_flags_t;
endpackage

// File: rtl/xg_frame_ctrl.sv
module xg_frame_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic sop_i,
  input  logic eop_i,
  input  logic xon_i,
  output logic pass_o
);
  logic in_frame_q;
  logic pass_q;
  logic start;

  assign start = valid_i & sop_i;

  // decision taken on the start beat, held until the end beat
  always_comb begin
    if (start)                  pass_o = xon_i;
    else if (valid_i && in_frame_q) pass_o = pass_q;
    else                        pass_o = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      pass_q     <= 1'b0;
    end else if (start) begin
      in_frame_q <= ~eop_i;
      pass_q     <= xon_i;
    end else if (valid_i && eop_i) begin
      in_frame_q <= 1'b0;
    end
  end

  p_eop_closes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eop_i) |=> !in_frame_q);

  p_stray_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sop_i && !in_frame_q) |-> !pass_o);

  p_single_beat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && eop_i) |=> !in_frame_q);
endmodule

// File: rtl/xg_beat_reg.sv
module xg_beat_reg
  import xg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pass_i,
  input  xg_flags_t         flags_i,
  input  logic [DATA_W-1:0] data_i,
  output xg_flags_t         flags_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
    end else begin
      flags_o.valid <= pass_i;
      flags_o.sop   <= pass_i & flags_i.sop;
      flags_o.eop   <= pass_i & flags_i.eop;
    end
  end

  // data only loads on forwarded beats
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_o <= '0;
    else if (pass_i) data_o <= data_i;
  end
endmodule

// File: rtl/stream_xon_gate.sv
module stream_xon_gate
  import xg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter bit BYPASS = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_xon_o,
  input  logic              out_xon_i,
  output logic              out_valid_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic [DATA_W-1:0] out_data_o
);
  assign in_xon_o = out_xon_i;

  generate
    if (BYPASS) begin : g_wire
      assign out_valid_o = in_valid_i;
      assign out_sop_o   = in_sop_i;
      assign out_eop_o   = in_eop_i;
      assign out_data_o  = in_data_i;
    end else begin : g_gate
      logic      pass;
      xg_flags_t in_flags;
      xg_flags_t out_flags;

      assign in_flags = '{valid: in_valid_i, sop: in_sop_i, eop: in_eop_i};

      xg_frame_ctrl u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .valid_i (in_valid_i),
        .sop_i   (in_sop_i),
        .eop_i   (in_eop_i),
        .xon_i   (out_xon_i),
        .pass_o  (pass)
      );

      xg_beat_reg #(.DATA_W(DATA_W)) u_reg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pass_i  (pass),
        .flags_i (in_flags),
        .data_i  (in_data_i),
        .flags_o (out_flags),
        .data_o  (out_data_o)
      );

      assign out_valid_o = out_flags.valid;
      assign out_sop_o   = out_flags.sop;
      assign out_eop_o   = out_flags.eop;

      p_start_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && in_sop_i && out_xon_i) |=>
          (out_valid_o && out_sop_o && out_data_o == $past(in_data_i)));

      p_start_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && in_sop_i && !out_xon_i) |=> !out_valid_o);

      p_marks_need_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !out_valid_o |-> (!out_sop_o && !out_eop_o));

      p_gap_no_beat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !out_valid_o);
    end
  endgenerate
endmodule

// File: tb/sim_stream_xon_gate.sv
module sim_stream_xon_gate;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v = 1'b0, s = 1'b0, e = 1'b0, x = 1'b0;
  logic [DW-1:0] d = '0;

  logic xo0, ov0, os0, oe0;
  logic [DW-1:0] od0;
  logic xo1, ov1, os1, oe1;
  logic [DW-1:0] od1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2ns clk = ~clk;

  stream_xon_gate #(.DATA_W(DW), .BYPASS(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(v), .in_sop_i(s), .in_eop_i(e),
    .in_data_i(d), .in_xon_o(xo0), .out_xon_i(x), .out_valid_o(ov0),
    .out_sop_o(os0), .out_eop_o(oe0), .out_data_o(od0));

  stream_xon_gate #(.DATA_W(DW), .BYPASS(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(v), .in_sop_i(s), .in_eop_i(e),
    .in_data_i(d), .in_xon_o(xo1), .out_xon_i(x), .out_valid_o(ov1),
    .out_sop_o(os1), .out_eop_o(oe1), .out_data_o(od1));

  // behavioural reference: frame state plus expected next output beat
  bit m_open, m_pass;
  bit ex_v, ex_s, ex_e;
  logic [DW-1:0] ex_d;
  string ex_tag = "R2";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_open = 0; m_pass = 0; ex_v = 0; ex_s = 0; ex_e = 0; ex_tag = "R2";
    end else begin
      bit fwd;
      fwd = 0;
      if (v && s) begin
        fwd = x; m_pass = x; m_open = !e;
        if (e) ex_tag = "R7";
        else if (m_open && x) ex_tag = "R3";
        else ex_tag = x ? "R11" : "R4";
      end else if (v && m_open) begin
        fwd = m_pass;
        ex_tag = m_pass ? "R5" : "R4";
        if (e) m_open = 0;
      end else if (v) begin
        ex_tag = "R6";
      end else begin
        ex_tag = m_open ? "R10" : "R8";
      end
      ex_v = fwd; ex_s = fwd && s; ex_e = fwd && e;
      if (fwd) ex_d = d;
    end
  end

  task automatic check(string tag, bit ok, string act, string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %s expected %s @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit nv, bit ns, bit ne, logic [DW-1:0] nd, bit nx);
    @(negedge clk);
    check(ex_tag, {ov0, os0, oe0} == {ex_v, ex_s, ex_e},
          $sformatf("v%0b s%0b e%0b", ov0, os0, oe0),
          $sformatf("v%0b s%0b e%0b", ex_v, ex_s, ex_e));
    if (ex_v)
      check(ex_tag, od0 == ex_d, $sformatf("%h", od0), $sformatf("%h", ex_d));
    v = nv; s = ns; e = ne; d = nd; x = nx;
    #1ns;
    check("R1", xo0 == x && xo1 == x, $sformatf("%0b%0b", xo0, xo1), $sformatf("%0b%0b", x, x));
    check("R9", {ov1, os1, oe1, od1} == {v, s, e, d},
          $sformatf("%0b%0b%0b %h", ov1, os1, oe1, od1),
          $sformatf("%0b%0b%0b %h", v, s, e, d));
  endtask

  task automatic frame(int len, bit xs, bit xm, int gap_at);
    for (int i = 0; i < len; i++) begin
      if (i == gap_at) step(0, 0, 0, '0, xm);
      step(1, i == 0, i == len - 1, DW'($urandom), (i == 0) ? xs : xm);
    end
  endtask

  initial begin
    #400000ns;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: outputs low during reset
    check("R2", {ov0, os0, oe0} == 3'b000, $sformatf("%0b%0b%0b", ov0, os0, oe0), "000");
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, '0, 1);
    check("R2", {ov0, os0, oe0} == 3'b000, $sformatf("%0b%0b%0b", ov0, os0, oe0), "000");
    frame(4, 1, 1, 2);          // R3 pass with R10 gap
    frame(4, 0, 1, 1);          // R4 drop though xon rises
    frame(5, 1, 0, 3);          // R5 completes though xon falls
    step(1, 0, 0, 16'h1234, 1); // R6 stray
    step(1, 0, 1, 16'h5678, 1); // R6 stray end
    step(1, 1, 1, 16'h0aaa, 1); // R7 single, pass
    step(1, 1, 1, 16'h0bbb, 0); // R7 single, drop
    step(1, 1, 0, 16'h0c01, 0); // open dropped frame
    step(1, 0, 0, 16'h0c02, 1);
    step(1, 1, 0, 16'h0d01, 1); // R11 restart, pass
    step(1, 0, 1, 16'h0d02, 0);
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      step(r != 0, r < 3, (r == 2) || (r > 6), DW'($urandom), $urandom_range(0, 3) != 0);
    end
    step(0, 0, 0, '0, 1);
    step(0, 0, 0, '0, 1);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule